// File: doc/BRIEF.md
# VGA Memory Address Generator

This block turns a legacy display access address in the A0000h to BFFFFh window into a dword address in the VGA area of graphics memory. It also produces the byte-lane enables that pick which of the four planes the access touches. The VGA area holds 256 KB arranged as 64K words of 32 bits, with one byte lane per plane. Because the area starts on a 256 KB boundary, the physical address is built by joining the upper base bits to the word index, not by adding a base to an offset.

Each request is presented for one cycle with its address, the base register value, a two-bit addressing mode and a map-mask. One cycle later the block shows the registered result. It also flags a base value that is not 256 KB aligned. Three addressing modes decide how the window offset becomes a word index and a plane selection: planar, odd/even and chain-4.

A two-state controller sequences the result. ST_IDLE means no result is on the outputs. ST_LIVE means the outputs carry the result of the request taken on the previous edge. The transition *take* (req_valid high) enters or stays in ST_LIVE. The transition *drain* (req_valid low) enters or stays in ST_IDLE. Reset forces ST_IDLE.

Top module: `vga_agen_top`

## Requirements
- R1: out_valid is high in the cycle after each clock edge that samples req_valid high, and low after an edge that samples req_valid low.
- R2: While rst_n is low and after its release, out_valid, phys_addr, plane_en and cfg_err are all zero until the first request is taken.
- R3: phys_addr equals base[31:18], then the 16-bit word index, then two zero bits, from high to low.
- R4: The window offset is vga_addr minus A0000h, 17 bits wide. Modes 2'b00 and 2'b11 are planar, and in planar mode the word index is offset[15:0].
- R5: In odd/even mode (2'b01) the word index is offset[16:1]. The plane pair is planes 0 and 2 (enables 4'b0101) when vga_addr bit 0 is 0, and planes 1 and 3 (4'b1010) when it is 1.
- R6: In chain-4 mode (2'b10) the word index is offset[16:2], zero-extended to 16 bits. The single plane is the one numbered by vga_addr[1:0], with enable bit n meaning plane n.
- R7: plane_en is the mode's plane selection ANDed with map_mask. In planar mode it equals map_mask.
- R8: cfg_err is high exactly when base[17:0] is nonzero. A misaligned base does not change how phys_addr is formed.
- R9: After a clock edge that samples req_valid low, phys_addr, plane_en and cfg_err keep their previous values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe for this cycle |
| vga_addr | input | 20 | Access address, A0000h to BFFFFh |
| vga_base | input | 32 | Base of the VGA area in graphics memory |
| addr_mode | input | 2 | 00 planar, 01 odd/even, 10 chain-4, 11 planar |
| map_mask | input | 4 | Plane write mask, bit n for plane n |
| out_valid | output | 1 | Result of the previous cycle's request is present |
| phys_addr | output | 32 | Physical byte address of the target dword |
| plane_en | output | 4 | Byte-lane (plane) enables |
| cfg_err | output | 1 | Base is not 256 KB aligned |

## Verification
The controller state is visible directly on out_valid. A state stuck in ST_LIVE or ST_IDLE therefore shows up in the first cycle after a drain or a take. The result registers are loaded only on a take. A wrong load enable shows within one cycle, as output values that move during a drain or that stay stale after a take. A fault in the mode decode shows in the same cycle as the result: for example a word index shifted by the wrong amount, or a plane pair taken from the wrong address bit. The vectors place boundary offsets under every mode so that each such fault changes the value seen at the ports.

// File: rtl/vga_agen_pkg.sv
package vga_agen_pkg;

    typedef enum logic [1:0] {
        MODE_PLANAR     = 2'b00,
        MODE_ODDEVEN    = 2'b01,
        MODE_CHAIN4     = 2'b10,
        MODE_PLANAR_ALT = 2'b11
    } agen_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_LIVE = 1'b1
    } agen_state_e;

endpackage

// File: rtl/vga_agen_remap.sv
module vga_agen_remap
    import vga_agen_pkg::*;
#(
    parameter int OFF_W  = 17,
    parameter int WORD_W = 16
) (
    input  logic [OFF_W-1:0]  win_off,
    input  agen_mode_e        mode,
    output logic [WORD_W-1:0] word_idx
);

    // Each mode folds the window offset by a different shift.
    always_comb begin
        unique case (mode)
            MODE_ODDEVEN: word_idx = WORD_W'(win_off >> 1);
            MODE_CHAIN4:  word_idx = WORD_W'(win_off >> 2);
            default:      word_idx = WORD_W'(win_off);
        endcase
    end

endmodule

// File: rtl/vga_agen_plane.sv
module vga_agen_plane
    import vga_agen_pkg::*;
#(
    parameter int PLANES = 4
) (
    input  logic [$clog2(PLANES)-1:0] low_addr,
    input  agen_mode_e                mode,
    input  logic [PLANES-1:0]         mask,
    output logic [PLANES-1:0]         lane_en
);

    localparam int SEL_W = $clog2(PLANES);

    for (genvar p = 0; p < PLANES; p++) begin : g_lane
        localparam logic [SEL_W-1:0] LANE = SEL_W'(p);
        logic hit;
        always_comb begin
            unique case (mode)
                MODE_CHAIN4:  hit = (low_addr == LANE);
                MODE_ODDEVEN: hit = (low_addr[0] == LANE[0]);
                default:      hit = 1'b1;
            endcase
        end
        assign lane_en[p] = hit & mask[p];
    end

endmodule

// File: rtl/vga_agen_basechk.sv
module vga_agen_basechk #(
    parameter int ALIGN_W = 18
) (
    input  logic [ALIGN_W-1:0] base_low,
    output logic               misaligned
);

    assign misaligned = |base_low;

endmodule

// File: rtl/vga_agen_top.sv
module vga_agen_top
    import vga_agen_pkg::*;
#(
    parameter int              ADDR_W   = 20,
    parameter logic [19:0]     WIN_BASE = 20'hA0000,
    parameter int              OFF_W    = 17,
    parameter int              WORD_W   = 16,
    parameter int              PHYS_W   = 32,
    parameter int              PLANES   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] vga_addr,
    input  logic [PHYS_W-1:0] vga_base,
    input  logic [1:0]        addr_mode,
    input  logic [PLANES-1:0] map_mask,
    output logic              out_valid,
    output logic [PHYS_W-1:0] phys_addr,
    output logic [PLANES-1:0] plane_en,
    output logic              cfg_err
);

    localparam int LANE_W  = $clog2(PLANES);
    localparam int ALIGN_W = WORD_W + LANE_W;

    agen_state_e       state_q, state_d;
    agen_mode_e        mode;
    logic [ADDR_W-1:0] win_full;
    logic [OFF_W-1:0]  win_off;
    logic [WORD_W-1:0] word_idx;
    logic [PLANES-1:0] lane_en;
    logic              misaligned;
    logic [PHYS_W-1:0] phys_d;

    assign mode     = agen_mode_e'(addr_mode);
    assign win_full = vga_addr - ADDR_W'(WIN_BASE);
    assign win_off  = win_full[OFF_W-1:0];

    vga_agen_remap #(.OFF_W(OFF_W), .WORD_W(WORD_W)) u_remap (
        .win_off  (win_off),
        .mode     (mode),
        .word_idx (word_idx)
    );

    vga_agen_plane #(.PLANES(PLANES)) u_plane (
        .low_addr (vga_addr[LANE_W-1:0]),
        .mode     (mode),
        .mask     (map_mask),
        .lane_en  (lane_en)
    );

    vga_agen_basechk #(.ALIGN_W(ALIGN_W)) u_basechk (
        .base_low   (vga_base[ALIGN_W-1:0]),
        .misaligned (misaligned)
    );

    // Aligned base: join instead of add.
    assign phys_d = {vga_base[PHYS_W-1:ALIGN_W], word_idx, {LANE_W{1'b0}}};

    // Next-state logic: take / drain.
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_LIVE : ST_IDLE;
            ST_LIVE: state_d = req_valid ? ST_LIVE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Result registers, loaded only on a take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phys_addr <= '0;
            plane_en  <= '0;
            cfg_err   <= 1'b0;
        end else if (req_valid) begin
            phys_addr <= phys_d;
            plane_en  <= lane_en;
            cfg_err   <= misaligned;
        end
    end

    assign out_valid = (state_q == ST_LIVE);

    // R4: requests are expected inside the legacy window.
    a_r4_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (win_full[ADDR_W-1:OFF_W] == '0));

    // R1: one-cycle result strobe.
    a_r1_take: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid);
    a_r1_drain: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid);

    // R3: upper address bits follow the base sampled with the request.
    a_r3_base_join: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (phys_addr[PHYS_W-1:ALIGN_W] == $past(vga_base[PHYS_W-1:ALIGN_W])));

    // R6: chain-4 never enables more than one plane.
    a_r6_single_plane: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && addr_mode == MODE_CHAIN4) |=> ($countones(plane_en) <= 1));

    // R5: odd/even never enables a plane of the wrong parity.
    a_r5_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && addr_mode == MODE_ODDEVEN && !vga_addr[0]) |=> (plane_en[1] == 1'b0 && plane_en[3] == 1'b0));

    // R7: no plane outside the map-mask.
    a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> ((plane_en & ~$past(map_mask)) == '0));

    // R8: alignment flag tracks low base bits.
    a_r8_align_flag: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (cfg_err == ($past(vga_base[ALIGN_W-1:0]) != '0)));

    // R9: results hold without a request.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(phys_addr) && $stable(plane_en) && $stable(cfg_err)));

endmodule

// File: tb/vga_agen_top_test.sv
`timescale 1ns/100ps
module vga_agen_top_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [19:0] vga_addr;
    logic [31:0] vga_base;
    logic [1:0]  addr_mode;
    logic [3:0]  map_mask;
    logic        out_valid;
    logic [31:0] phys_addr;
    logic [3:0]  plane_en;
    logic        cfg_err;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    vga_agen_top uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .vga_addr(vga_addr), .vga_base(vga_base), .addr_mode(addr_mode),
        .map_mask(map_mask), .out_valid(out_valid), .phys_addr(phys_addr),
        .plane_en(plane_en), .cfg_err(cfg_err)
    );

    typedef struct packed {
        logic [19:0] addr;
        logic [31:0] base;
        logic [1:0]  mode;
        logic [3:0]  mask;
        logic [31:0] phys;
        logic [3:0]  en;
        logic        err;
        logic [3:0]  rid;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{20'hA0000, 32'h0804_0000, 2'b00, 4'hF, 32'h0804_0000, 4'hF, 1'b0, 4'd4}, // R4 planar start
        '{20'hAFFFC, 32'h0804_0000, 2'b00, 4'h5, 32'h0807_FFF0, 4'h5, 1'b0, 4'd4}, // R4 R7
        '{20'hB1234, 32'h0804_0000, 2'b00, 4'hA, 32'h0804_48D0, 4'hA, 1'b0, 4'd4}, // R4 wrap of bit 16
        '{20'hA0001, 32'h0804_0000, 2'b01, 4'hF, 32'h0804_0000, 4'hA, 1'b0, 4'd5}, // R5 odd
        '{20'hA1000, 32'h0804_0000, 2'b01, 4'hF, 32'h0804_2000, 4'h5, 1'b0, 4'd5}, // R5 even
        '{20'hBFFFF, 32'h0804_0000, 2'b01, 4'h3, 32'h0807_FFFC, 4'h2, 1'b0, 4'd5}, // R5 top, masked
        '{20'hA0003, 32'h0804_0000, 2'b10, 4'hF, 32'h0804_0000, 4'h8, 1'b0, 4'd6}, // R6 plane 3
        '{20'hA0006, 32'h0804_0000, 2'b10, 4'hF, 32'h0804_0004, 4'h4, 1'b0, 4'd6}, // R6 plane 2
        '{20'hBFFFD, 32'h0804_0000, 2'b10, 4'hF, 32'h0805_FFFC, 4'h2, 1'b0, 4'd6}, // R6 top
        '{20'hA0001, 32'h0804_0000, 2'b10, 4'hD, 32'h0804_0000, 4'h0, 1'b0, 4'd7}, // R7 masked out
        '{20'hA0010, 32'h0804_0000, 2'b11, 4'h6, 32'h0804_0040, 4'h6, 1'b0, 4'd4}, // R4 alt planar
        '{20'hA0004, 32'h0804_0100, 2'b00, 4'hF, 32'h0804_0010, 4'hF, 1'b1, 4'd8}, // R8 misaligned
        '{20'hA0000, 32'hFFFC_0000, 2'b10, 4'h1, 32'hFFFC_0000, 4'h1, 1'b0, 4'd3}, // R3 high base
        '{20'hA0000, 32'h0000_0001, 2'b00, 4'h0, 32'h0000_0000, 4'h0, 1'b1, 4'd8}  // R8 low bit
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [19:0] a, input logic [31:0] b,
                         input logic [1:0] m, input logic [3:0] k);
        req_valid = v; vga_addr = a; vga_base = b; addr_mode = m; map_mask = k;
    endtask

    initial begin
        drive(1'b0, 20'hA0000, 32'h0, 2'b00, 4'h0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R2: reset state
        check("R2 out_valid", {31'b0, out_valid}, 32'h0);
        check("R2 phys_addr", phys_addr, 32'h0);
        check("R2 plane_en", {28'b0, plane_en}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 after release", {27'b0, out_valid, plane_en}, 32'h0);
        check("R2 cfg_err", {31'b0, cfg_err}, 32'h0);

        // Vector table, back to back.
        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VECS[i].addr, VECS[i].base, VECS[i].mode, VECS[i].mask);
            @(negedge clk);
            check($sformatf("R%0d vec %0d phys (R3)", VECS[i].rid, i), phys_addr, VECS[i].phys);
            check($sformatf("R%0d vec %0d plane_en", VECS[i].rid, i), {28'b0, plane_en}, {28'b0, VECS[i].en});
            check($sformatf("R8 vec %0d cfg_err", i), {31'b0, cfg_err}, {31'b0, VECS[i].err});
            check($sformatf("R1 vec %0d out_valid", i), {31'b0, out_valid}, 32'h1);
        end

        // R9: drain with changed inputs; outputs hold the last vector's result.
        drive(1'b0, 20'hA0007, 32'h1234_5678, 2'b10, 4'hF);
        @(negedge clk);
        check("R1 drain out_valid", {31'b0, out_valid}, 32'h0);
        check("R9 phys hold", phys_addr, 32'h0000_0000);
        check("R9 plane hold", {28'b0, plane_en}, 32'h0);
        check("R9 err hold", {31'b0, cfg_err}, 32'h1);
        @(negedge clk);
        check("R9 phys still held", phys_addr, 32'h0000_0000);

        // R1: single take after idle, then drain.
        drive(1'b1, 20'hA0005, 32'h0804_0000, 2'b01, 4'hF);
        @(negedge clk);
        check("R1 take", {31'b0, out_valid}, 32'h1);
        check("R5 directed phys", phys_addr, 32'h0804_0008);
        check("R5 directed en", {28'b0, plane_en}, 32'hA);
        drive(1'b0, 20'hA0000, 32'h0, 2'b00, 4'h0);
        @(negedge clk);
        check("R1 drain", {31'b0, out_valid}, 32'h0);
        check("R9 directed hold", phys_addr, 32'h0804_0008);

        // R2: reset in mid-stream clears the outputs.
        drive(1'b1, 20'hA0004, 32'h0804_0000, 2'b00, 4'hF);
        rst_n = 1'b0;
        @(negedge clk);
        check("R2 mid reset valid", {31'b0, out_valid}, 32'h0);
        check("R2 mid reset phys", phys_addr, 32'h0);
        drive(1'b0, 20'hA0000, 32'h0, 2'b00, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule